// File: doc/BRIEF.md
# Gated Configuration Register Port

This block is the configuration front end of a multi-function I/O device. It is reached through two byte-wide ports on a simple synchronous 8-bit bus. The index port takes a register number and the data port reads or writes the register it names. Configuration access stays shut after reset. It opens only when the entry byte 0x87 has been written to the index port twice, with no other index write between. Writing 0xAA to the index port shuts it again.

Registers below 0x30 are global: a logical-device selector at 0x07 and a small block of scratch bytes starting at 0x20. Registers at 0x30 and above live in one bank per logical device. The selector picks the bank that these indices reach. Each bank holds an activate bit, two 16-bit base addresses, an IRQ number and an IRQ type. The activate bits of all banks are driven out as the enables of the peripherals.

Top module: `gated_cfg_port`

## Requirements
- R1: Two index-port writes of 0x87, with no other index-port write between them, open the gate. Until then the data port reads 0xFF.
- R2: While the gate is open, an index-port write of 0xAA closes it and leaves the stored index unchanged. Opening the gate again takes two more 0x87 writes.
- R3: An index-port write of any value other than 0x87 before the gate opens discards a 0x87 seen earlier. After 0x87, 0x55, 0x87 the gate is still closed, and one more 0x87 opens it.
- R4: While the gate is closed, data-port writes change no register, and reads of both the index port (addr 0) and the data port (addr 1) return 0xFF.
- R5: While the gate is open, an index-port write other than 0xAA stores the index. The index port reads it back, and the data port reads the register that the index names.
- R6: Register 0x07 holds the logical device number in its low 3 bits, and its upper bits read 0. Each of the 8 devices keeps its own bank at indices 0x30 and above.
- R7: In the selected bank, bit 0 of register 0x30 is the activate bit, and its other bits read 0. dev_active_o[n] equals the activate bit of device n.
- R8: In each bank, 0x60 and 0x61 hold the high and low bytes of the first base address, and 0x62 and 0x63 hold the second. All four are full 8-bit registers.
- R9: In each bank, 0x70 holds the IRQ number in its low 4 bits and 0x71 holds the IRQ type in its low 2 bits (0x02 means active high, edge triggered). Upper bits read 0.
- R10: Indices 0x20 to 0x2F are 8-bit global read/write registers. Any other unimplemented index reads 0x00.
- R11: After reset the gate is closed, the index is 0x00, and every register, including each activate bit, is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| addr_i | input | 1 | Port select: 0 index, 1 data |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte of the port named by addr_i |
| dev_active_o | output | 8 | Activate bit of each logical device |

## Verification
The unlock logic is tried with a clean double entry key, with a single key, and with a key split by a foreign byte. These three cases separate a design that counts keys in a row from one that only counts keys or ignores them. Writes and reads with the gate closed show whether the gate really blocks the data path rather than only the readback. Every one of the eight banks gets a different pattern in each field. This exposes banks that alias one another and fields that keep bits the requirements say read as 0. The activate vector then shows whether the per-device outputs follow the right bank.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [1:0] {KEY_LOCKED, KEY_HALF, KEY_OPEN} key_state_e;

  localparam logic [7:0] ENTRY_KEY   = 8'h87;
  localparam logic [7:0] EXIT_KEY    = 8'hAA;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_GLB     = 8'h20;
  localparam logic [7:0] IDX_BANK    = 8'h30;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [5:0] IDX_BASE_HI = 6'b011000; // 0x60..0x63
  localparam logic [7:0] IDX_IRQ     = 8'h70;
  localparam logic [7:0] IDX_IRQTYPE = 8'h71;
  localparam logic [7:0] CLOSED_RD   = 8'hFF;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o,
  output logic       idx_load_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr_i) begin
      unique case (state_q)
        KEY_LOCKED: state_d = (wdata_i == ENTRY_KEY) ? KEY_HALF : KEY_LOCKED;
        KEY_HALF:   state_d = (wdata_i == ENTRY_KEY) ? KEY_OPEN : KEY_LOCKED;
        KEY_OPEN:   state_d = (wdata_i == EXIT_KEY)  ? KEY_LOCKED : KEY_OPEN;
        default:    state_d = KEY_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_LOCKED;
    else         state_q <= state_d;
  end

  assign open_o     = (state_q == KEY_OPEN);
  assign idx_load_o = idx_wr_i && open_o && (wdata_i != EXIT_KEY);

  // R1
  gate_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> ($past(idx_wr_i) && $past(wdata_i) == ENTRY_KEY && $past(state_q) == KEY_HALF));

  // R2
  exit_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_wr_i && wdata_i == EXIT_KEY) |=> !open_o);

  // R3
  key_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == KEY_HALF && idx_wr_i && wdata_i != ENTRY_KEY) |=> (state_q == KEY_LOCKED));
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_port_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int NUM_GLB = 16,
  localparam int LDN_W  = $clog2(NUM_DEV),
  localparam int GLB_W  = $clog2(NUM_GLB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic [LDN_W-1:0] ldn_o
);
  logic [LDN_W-1:0] ldn_q;
  logic [7:0]       glb_q [NUM_GLB];
  logic [7:0]       off;
  logic             in_glb;

  assign off    = idx_i - IDX_GLB;
  assign in_glb = (idx_i >= IDX_GLB) && (off < 8'(NUM_GLB));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q <= '0;
      for (int i = 0; i < NUM_GLB; i++) glb_q[i] <= '0;
    end else if (wr_i) begin
      if (idx_i == IDX_LDN) ldn_q <= wdata_i[LDN_W-1:0];
      else if (in_glb)      glb_q[off[GLB_W-1:0]] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i == IDX_LDN) rdata_o = 8'(ldn_q);
    else if (in_glb)      rdata_o = glb_q[off[GLB_W-1:0]];
  end

  assign ldn_o = ldn_q;
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       active_o
);
  logic       act_q;
  logic [7:0] base_q [4];
  logic [3:0] irq_q;
  logic [1:0] type_q;
  logic       we;

  assign we = wr_i && sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      irq_q  <= '0;
      type_q <= '0;
      for (int i = 0; i < 4; i++) base_q[i] <= '0;
    end else if (we) begin
      if (idx_i == IDX_ACT)               act_q  <= wdata_i[0];
      else if (idx_i[7:2] == IDX_BASE_HI) base_q[idx_i[1:0]] <= wdata_i;
      else if (idx_i == IDX_IRQ)          irq_q  <= wdata_i[3:0];
      else if (idx_i == IDX_IRQTYPE)      type_q <= wdata_i[1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i == IDX_ACT)               rdata_o = {7'd0, act_q};
    else if (idx_i[7:2] == IDX_BASE_HI) rdata_o = base_q[idx_i[1:0]];
    else if (idx_i == IDX_IRQ)          rdata_o = {4'd0, irq_q};
    else if (idx_i == IDX_IRQTYPE)      rdata_o = {6'd0, type_q};
  end

  assign active_o = act_q;

  // R7
  act_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && idx_i == IDX_ACT) |=> (active_o == $past(wdata_i[0])));

  // R6
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(active_o));
endmodule

// File: rtl/gated_cfg_port.sv
module gated_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int NUM_GLB = 16,
  localparam int LDN_W  = $clog2(NUM_DEV)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic [NUM_DEV-1:0] dev_active_o
);
  logic             cfg_open, idx_load, dat_wr, glb_wr, bank_wr;
  logic [7:0]       idx_q, glb_rd;
  logic [LDN_W-1:0] ldn;
  logic [7:0]       bank_rd [NUM_DEV];

  cfg_key_fsm u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (wr_en_i && !addr_i),
    .wdata_i    (wdata_i),
    .open_o     (cfg_open),
    .idx_load_o (idx_load)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_load) idx_q <= wdata_i;
  end

  assign dat_wr  = wr_en_i && addr_i && cfg_open;
  assign glb_wr  = dat_wr && (idx_q < IDX_BANK);
  assign bank_wr = dat_wr && (idx_q >= IDX_BANK);

  cfg_global_regs #(.NUM_DEV(NUM_DEV), .NUM_GLB(NUM_GLB)) u_glb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (glb_wr),
    .idx_i   (idx_q),
    .wdata_i (wdata_i),
    .rdata_o (glb_rd),
    .ldn_o   (ldn)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
    cfg_dev_bank u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (ldn == LDN_W'(d)),
      .wr_i     (bank_wr),
      .idx_i    (idx_q),
      .wdata_i  (wdata_i),
      .rdata_o  (bank_rd[d]),
      .active_o (dev_active_o[d])
    );
  end

  always_comb begin
    if (!cfg_open)              rdata_o = CLOSED_RD;
    else if (!addr_i)           rdata_o = idx_q;
    else if (idx_q >= IDX_BANK) rdata_o = bank_rd[ldn];
    else                        rdata_o = glb_rd;
  end

  // R4
  closed_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_open && wr_en_i && addr_i) |=> ($stable(ldn) && $stable(dev_active_o)));

  // R5
  idx_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_open && wr_en_i && !addr_i && wdata_i != EXIT_KEY) |=> (idx_q == $past(wdata_i)));

  // R2
  exit_keeps_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wdata_i == EXIT_KEY) |=> $stable(idx_q));
endmodule

// File: tb/sim_gated_cfg_port.sv
module sim_gated_cfg_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] dev_active_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  gated_cfg_port u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .dev_active_o(dev_active_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk_i);
    addr_i = a; wdata_i = v; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr_i = a; wr_en_i = 1'b0;
    #1;
    v = rdata_o;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
    wr(1'b0, idx);
    wr(1'b1, v);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] v);
    wr(1'b0, idx);
    rd(1'b1, v);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1'b0, v); chk("R11 R4 index read closed", v, 8'hFF);
    rd(1'b1, v); chk("R11 R4 data read closed", v, 8'hFF);
    chk("R11 activate bits", dev_active_o, 8'h00);
  endtask

  task automatic t_unlock;
    logic [7:0] v;
    wr(1'b0, 8'h87);
    rd(1'b1, v); chk("R1 single key stays closed", v, 8'hFF);
    wr(1'b0, 8'h87);
    rd(1'b0, v); chk("R1 R11 open, index reset value", v, 8'h00);
    reg_rd(8'h07, v); chk("R11 ldn reset", v, 8'h00);
  endtask

  task automatic t_close_and_ignore;
    logic [7:0] v;
    wr(1'b0, 8'h20);
    wr(1'b0, 8'hAA);
    rd(1'b0, v); chk("R2 closed after exit key", v, 8'hFF);
    wr(1'b1, 8'h33);
    wr(1'b0, 8'h87);
    rd(1'b1, v); chk("R2 one key after exit", v, 8'hFF);
    wr(1'b0, 8'h87);
    rd(1'b0, v); chk("R2 index kept over exit", v, 8'h20);
    rd(1'b1, v); chk("R4 closed data write ignored", v, 8'h00);
  endtask

  task automatic t_bad_key;
    logic [7:0] v;
    wr(1'b0, 8'hAA);
    wr(1'b0, 8'h87);
    wr(1'b0, 8'h55);
    wr(1'b0, 8'h87);
    rd(1'b1, v); chk("R3 split key stays closed", v, 8'hFF);
    wr(1'b0, 8'h87);
    rd(1'b0, v); chk("R3 key after split opens", v, 8'h20);
  endtask

  task automatic t_globals;
    logic [7:0] v;
    for (int i = 0; i < 16; i++) reg_wr(8'h20 + 8'(i), 8'h5A ^ 8'(i * 7));
    for (int i = 0; i < 16; i++) begin
      reg_rd(8'h20 + 8'(i), v); chk("R10 global readback", v, 8'h5A ^ 8'(i * 7));
    end
    reg_rd(8'h15, v); chk("R10 unimplemented global", v, 8'h00);
    reg_wr(8'h07, 8'hFD);
    reg_rd(8'h07, v); chk("R6 ldn 3 bits", v, 8'h05);
    rd(1'b0, v); chk("R5 index readback", v, 8'h07);
  endtask

  task automatic t_banks;
    logic [7:0] v;
    for (int d = 0; d < 8; d++) begin
      reg_wr(8'h07, 8'(d));
      reg_wr(8'h30, (d % 2 == 1) ? 8'hFF : 8'hFE);
      reg_wr(8'h60, 8'h10 + 8'(d));
      reg_wr(8'h61, 8'hA0 + 8'(d));
      reg_wr(8'h62, 8'h40 + 8'(d));
      reg_wr(8'h63, 8'hC0 + 8'(d));
      reg_wr(8'h70, 8'hF0 | 8'(d));
      reg_wr(8'h71, 8'hFE);
    end
    chk("R7 activate vector", dev_active_o, 8'hAA);
    for (int d = 0; d < 8; d++) begin
      reg_wr(8'h07, 8'(d));
      reg_rd(8'h30, v); chk("R7 R6 activate readback", v, 8'(d % 2));
      reg_rd(8'h60, v); chk("R8 base0 high", v, 8'h10 + 8'(d));
      reg_rd(8'h61, v); chk("R8 base0 low", v, 8'hA0 + 8'(d));
      reg_rd(8'h62, v); chk("R8 base1 high", v, 8'h40 + 8'(d));
      reg_rd(8'h63, v); chk("R8 base1 low", v, 8'hC0 + 8'(d));
      reg_rd(8'h70, v); chk("R9 irq number", v, 8'(d));
      reg_rd(8'h71, v); chk("R9 irq type", v, 8'h02);
      reg_rd(8'h40, v); chk("R10 unimplemented bank index", v, 8'h00);
    end
    reg_wr(8'h07, 8'd1);
    reg_wr(8'h30, 8'h00);
    chk("R7 deactivate device 1", dev_active_o, 8'hA8);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_unlock();
    t_close_and_ignore();
    t_bad_key();
    t_globals();
    t_banks();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule